// File: doc/BRIEF.md
# Indirect Control Register Port

This block is the host-facing register window of a network controller. The host reaches a bank of 16-bit control and status registers through a pair of ports. It first writes a register number into the index port. It then reads or writes the selected register through the data port. A second data port reaches the bus configuration registers and uses the same index. Reading the software-reset port returns the whole window to its reset state. The low offsets return a station address held as a parameter.

The central register is the command/status word, register 0. It mixes several kinds of bit:

- command bits that act once and read back as zero: start, stop, init and transmit poll;
- run-state bits that follow from those commands;
- an interrupt enable;
- seven event flags that the MAC side raises and the host clears by writing ones;
- two summary bits computed from the flags.

Registers 1 to 4 hold the initialisation-block address and two mode bits. Registers 88 and 89 return a fixed chip identifier.

The port can be accessed either 32 or 16 bits wide. In the narrow mode the offsets at and above 0x10 are packed to half their spacing. Bus protocol, DMA and the MAC datapath are outside the block.

Top module: `ctl_reg_window`

## Requirements
- R1: After the asynchronous reset, and after any read of the software-reset port, the following hold: register 0 reads 0x0004 (only the stop bit set), the index reads 0, registers 1 to 4 and bus register 20 read 0, and `irq_o`, `init_req_o` and `tx_poll_o` are low. The software-reset port reads 0.
- R2: Offsets 0x00 to 0x0F select the station address. In wide mode (`bus_wide_i`=1) the ports sit at data 0x10, index 0x14, reset 0x18 and bus data 0x1C. In narrow mode an offset o at or above 0x10 maps to 0x10 + 2*(o - 0x10), which puts the same ports at 0x10, 0x12, 0x14 and 0x16. Any other offset reads 0 and ignores writes.
- R3: A write to the index port stores the low 7 bits of the write data, and the index port reads them back. The data port reads and writes the register that the index selects, in bits 15:0 of `bus_rdata_o`, with the upper 16 bits zero. A register number that is not implemented reads 0 and ignores writes.
- R4: Register 0 holds seven event flags: bit8 init-done, bit9 tx-done, bit10 rx-done, bit11 memory error, bit12 missed frame, bit13 collision and bit14 transmit timeout. Each flag is set by its event input. Writing 1 to a flag's bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the flag set.
- R5: Bit15 of register 0 reads as the OR of bits 11 to 14. Bit7 reads as the OR of bit15, bit9, bit10 and bit8. Bit8 counts toward bit7 only while register 3 bit8 (init-done mask) is 0.
- R6: Bit6 of register 0 is the interrupt enable and takes the written value on every register-0 write. `irq_o` is high exactly when bits 7 and 6 are both 1.
- R7: Register 0 bit2 is stop, bit1 is start, bit4 is tx-on and bit5 is rx-on. Writing 1 to bit2 sets stop and clears start, tx-on and rx-on. Otherwise, writing 1 to bit1 clears stop and sets start, tx-on and rx-on. Stop has priority when both are written.
- R8: Writing 1 to bit0 of register 0 without bit2 gives a one-cycle `init_req_o` pulse in the cycle after the write. Bit0 reads 0. `init_done_i` sets the init-done flag.
- R9: Writing 1 to bit3 of register 0 gives a one-cycle `tx_poll_o` pulse in the cycle after the write. Bit3 reads 0.
- R10: Registers 88 and 89 return the low and high halves of `CHIP_ID` (default 0x02420003). Writes to them are ignored.
- R11: `ib_addr_o` is register 2 in bits 31:16 and register 1 in bits 15:0. `idon_mask_o` is register 3 bit8. `auto_pad_o` is register 4 bit11.
- R12: The bus data port reads and writes bus register 20 when the index is 20, and reads 0 for any other index. `bus_style_o` is bus register 20 (2 selects 32-bit software style).
- R13: The station address is bytes b0..b5, with b0 in `STATION_ADDR[7:0]`. A wide read at 0x00 returns {b3,b2,b1,b0}, and a wide read at 0x04 returns {16'h0,b5,b4}. Narrow reads at 0x00, 0x02 and 0x04 return {b1,b0}, {b3,b2} and {b5,b4}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_wide_i | input | 1 | 1 = 32-bit access map, 0 = 16-bit map |
| bus_ofs_i | input | 5 | Byte offset within the window |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on the offset and index |
| ev_txtimeout_i | input | 1 | Sets the transmit-timeout flag |
| ev_collision_i | input | 1 | Sets the collision flag |
| ev_missed_i | input | 1 | Sets the missed-frame flag |
| ev_memerr_i | input | 1 | Sets the memory-error flag |
| ev_rxdone_i | input | 1 | Sets the rx-done flag |
| ev_txdone_i | input | 1 | Sets the tx-done flag |
| init_done_i | input | 1 | Sets the init-done flag |
| init_req_o | output | 1 | One-cycle initialisation request |
| tx_poll_o | output | 1 | One-cycle transmit poll |
| irq_o | output | 1 | Interrupt request |
| ib_addr_o | output | 32 | Initialisation-block address |
| idon_mask_o | output | 1 | Init-done interrupt mask |
| auto_pad_o | output | 1 | Automatic transmit padding enable |
| bus_style_o | output | 16 | Bus configuration register 20 |

## Verification
The hardest situation to reach from the ports is an event input that arrives in the very cycle the host writes a one to clear the same flag. The stimulus drives the collision event and the clearing register-0 write at the same falling edge, so both land on one rising edge. A second hard case is the init-done flag being set while it is masked. Here the flag must be visible in the register while the summary bit and `irq_o` stay low. The bench reaches it by writing the mask through register 3 and then returning the index to 0 before pulsing `init_done_i`.

// File: rtl/nicw_pkg.sv
`timescale 1ns/1ps
package nicw_pkg;
  localparam int DATA_W    = 16;
  localparam int OFS_W     = 5;
  localparam int REG_BASE  = 16;

  // register numbers reached through the index port
  localparam int IDX_CMD    = 0;
  localparam int IDX_ID_LO  = 88;
  localparam int IDX_ID_HI  = 89;
  localparam int IDX_BSTYLE = 20;

  // command/status bit positions
  localparam int B_INIT  = 0;
  localparam int B_START = 1;
  localparam int B_STOP  = 2;
  localparam int B_POLL  = 3;
  localparam int B_TXON  = 4;
  localparam int B_RXON  = 5;
  localparam int B_IEN   = 6;
  localparam int B_INTR  = 7;
  localparam int B_FLAG0 = 8;
  localparam int N_FLAG  = 7;
  localparam int B_ERR   = 15;

  localparam int CFG3_IDON_MASK = 8;
  localparam int CFG4_AUTOPAD   = 11;

  typedef enum logic [2:0] {
    PORT_NONE,
    PORT_PROM,
    PORT_DATA,
    PORT_INDEX,
    PORT_RESET,
    PORT_BUS
  } port_e;
endpackage

// File: rtl/nicw_port_decode.sv
`timescale 1ns/1ps
module nicw_port_decode
  import nicw_pkg::*;
(
  input  logic             wide_i,
  input  logic [OFS_W-1:0] ofs_i,
  output port_e            port_o
);
  logic [OFS_W:0] norm;
  logic           legal;

  always_comb begin
    norm   = '0;
    legal  = 1'b0;
    port_o = PORT_NONE;
    if (ofs_i < OFS_W'(REG_BASE)) begin
      port_o = PORT_PROM;
    end else begin
      if (wide_i) begin
        norm  = {1'b0, ofs_i};
        legal = (ofs_i[1:0] == 2'b00);
      end else begin
        norm  = (OFS_W+1)'(REG_BASE) + (({1'b0, ofs_i} - (OFS_W+1)'(REG_BASE)) << 1);
        legal = !ofs_i[0] && (ofs_i <= OFS_W'(REG_BASE + 6));
      end
      if (legal) begin
        case (norm)
          (OFS_W+1)'(REG_BASE + 0):  port_o = PORT_DATA;
          (OFS_W+1)'(REG_BASE + 4):  port_o = PORT_INDEX;
          (OFS_W+1)'(REG_BASE + 8):  port_o = PORT_RESET;
          (OFS_W+1)'(REG_BASE + 12): port_o = PORT_BUS;
          default:                   port_o = PORT_NONE;
        endcase
      end
    end
  end

  // R2: narrow offsets beyond the packed port range select nothing
  always_comb begin
    if (!wide_i && (ofs_i > OFS_W'(REG_BASE + 6)))
      p_narrow_range_r2: assert (port_o == PORT_NONE);
  end
endmodule

// File: rtl/nicw_cmd_status.sv
`timescale 1ns/1ps
module nicw_cmd_status
  import nicw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ev_txtimeout_i,
  input  logic              ev_collision_i,
  input  logic              ev_missed_i,
  input  logic              ev_memerr_i,
  input  logic              ev_rxdone_i,
  input  logic              ev_txdone_i,
  input  logic              init_done_i,
  input  logic              idon_mask_i,
  output logic [DATA_W-1:0] csr0_o,
  output logic              irq_o,
  output logic              init_req_o,
  output logic              tx_poll_o
);
  logic [N_FLAG-1:0] flag_q, flag_d, flag_set, flag_clr;
  logic stop_q, stop_d, run_q, run_d, txon_q, txon_d, rxon_q, rxon_d;
  logic ien_q, ien_d, initp_q, initp_d, poll_q, poll_d;
  logic upd_en, err, intr;
  logic unused_bits;

  assign unused_bits = ^{wdata_i[B_ERR], wdata_i[B_INTR], wdata_i[B_RXON], wdata_i[B_TXON]};

  // flag order matches bits 8..14
  assign flag_set = {ev_txtimeout_i, ev_collision_i, ev_missed_i, ev_memerr_i,
                     ev_rxdone_i, ev_txdone_i, init_done_i};
  assign flag_clr = wr_i ? wdata_i[B_FLAG0 +: N_FLAG] : '0;

  for (genvar k = 0; k < N_FLAG; k++) begin : g_flag
    assign flag_d[k] = flag_set[k] | (flag_q[k] & ~flag_clr[k]);
  end

  always_comb begin
    stop_d  = stop_q;
    run_d   = run_q;
    txon_d  = txon_q;
    rxon_d  = rxon_q;
    ien_d   = ien_q;
    initp_d = 1'b0;
    poll_d  = 1'b0;
    if (wr_i) begin
      ien_d = wdata_i[B_IEN];
      if (wdata_i[B_STOP]) begin
        stop_d = 1'b1;
        run_d  = 1'b0;
        txon_d = 1'b0;
        rxon_d = 1'b0;
      end else if (wdata_i[B_START]) begin
        stop_d = 1'b0;
        run_d  = 1'b1;
        txon_d = 1'b1;
        rxon_d = 1'b1;
      end
      initp_d = wdata_i[B_INIT] & ~wdata_i[B_STOP];
      poll_d  = wdata_i[B_POLL];
    end
  end

  assign upd_en = wr_i | (|flag_set) | initp_q | poll_q | soft_rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      stop_q  <= 1'b1;
      run_q   <= 1'b0;
      txon_q  <= 1'b0;
      rxon_q  <= 1'b0;
      ien_q   <= 1'b0;
      initp_q <= 1'b0;
      poll_q  <= 1'b0;
    end else if (upd_en) begin
      if (soft_rst_i) begin
        flag_q  <= '0;
        stop_q  <= 1'b1;
        run_q   <= 1'b0;
        txon_q  <= 1'b0;
        rxon_q  <= 1'b0;
        ien_q   <= 1'b0;
        initp_q <= 1'b0;
        poll_q  <= 1'b0;
      end else begin
        flag_q  <= flag_d;
        stop_q  <= stop_d;
        run_q   <= run_d;
        txon_q  <= txon_d;
        rxon_q  <= rxon_d;
        ien_q   <= ien_d;
        initp_q <= initp_d;
        poll_q  <= poll_d;
      end
    end
  end

  assign err  = |flag_q[6:3];
  assign intr = err | flag_q[2] | flag_q[1] | (flag_q[0] & ~idon_mask_i);

  assign csr0_o = {err, flag_q, intr, ien_q, rxon_q, txon_q, 1'b0, stop_q, run_q, 1'b0};
  assign irq_o      = intr & ien_q;
  assign init_req_o = initp_q;
  assign tx_poll_o  = poll_q;

  // R7: stopped state never has the transmitter or receiver on
  p_stop_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (!txon_q && !rxon_q));
  // R8: init request lasts one cycle
  p_init_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    init_req_o |=> !init_req_o);
  // R9: poll lasts one cycle
  p_poll_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll_o |=> !tx_poll_o);
  // R4: an event sets its flag even against a clear
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_txtimeout_i && !soft_rst_i) |=> csr0_o[14]);
  // R4: writing one clears a flag when no event competes
  p_flag_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[9] && !ev_txdone_i) |=> !csr0_o[9]);
  // R6: enabled error summary raises the interrupt
  p_irq_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (csr0_o[B_IEN] && csr0_o[B_ERR]) |-> irq_o);
endmodule

// File: rtl/nicw_cfg_regs.sv
`timescale 1ns/1ps
module nicw_cfg_regs
  import nicw_pkg::*;
#(
  parameter int          IDX_W   = 7,
  parameter logic [31:0] CHIP_ID = 32'h0242_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              csr_wr_i,
  input  logic              bus_wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] csr_rdata_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [31:0]       ib_addr_o,
  output logic              idon_mask_o,
  output logic              auto_pad_o,
  output logic [DATA_W-1:0] bus_style_o
);
  localparam int NCSR = 4;
  localparam logic [IDX_W-1:0] I_ID_LO  = IDX_W'(IDX_ID_LO);
  localparam logic [IDX_W-1:0] I_ID_HI  = IDX_W'(IDX_ID_HI);
  localparam logic [IDX_W-1:0] I_BSTYLE = IDX_W'(IDX_BSTYLE);

  logic [NCSR*DATA_W-1:0] csr_flat;
  logic [DATA_W-1:0]      style_q;
  logic                   style_en;

  for (genvar k = 0; k < NCSR; k++) begin : g_csr
    logic [DATA_W-1:0] q;
    logic              en;
    assign en = soft_rst_i || (csr_wr_i && (idx_i == IDX_W'(k + 1)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (en)     q <= soft_rst_i ? '0 : wdata_i;
    end
    assign csr_flat[k*DATA_W +: DATA_W] = q;
  end

  assign style_en = soft_rst_i || (bus_wr_i && (idx_i == I_BSTYLE));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        style_q <= '0;
    else if (style_en) style_q <= soft_rst_i ? '0 : wdata_i;
  end

  always_comb begin
    csr_rdata_o = '0;
    for (int k = 0; k < NCSR; k++)
      if (idx_i == IDX_W'(k + 1)) csr_rdata_o = csr_flat[k*DATA_W +: DATA_W];
    if (idx_i == I_ID_LO) csr_rdata_o = CHIP_ID[15:0];
    if (idx_i == I_ID_HI) csr_rdata_o = CHIP_ID[31:16];
  end

  assign bus_rdata_o = (idx_i == I_BSTYLE) ? style_q : '0;
  assign ib_addr_o   = csr_flat[2*DATA_W-1:0];
  assign idon_mask_o = csr_flat[2*DATA_W + CFG3_IDON_MASK];
  assign auto_pad_o  = csr_flat[3*DATA_W + CFG4_AUTOPAD];
  assign bus_style_o = style_q;

  // R10: identifier halves survive writes
  p_id_const_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr_i && idx_i == I_ID_LO) |=> (idx_i != I_ID_LO || csr_rdata_o == CHIP_ID[15:0]));
  // R12: bus register 20 changes only through its port or a reset
  p_style_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_i && !soft_rst_i) |=> $stable(bus_style_o));
endmodule

// File: rtl/ctl_reg_window.sv
`timescale 1ns/1ps
module ctl_reg_window
  import nicw_pkg::*;
#(
  parameter int          IDX_W        = 7,
  parameter logic [31:0] CHIP_ID      = 32'h0242_0003,
  parameter logic [47:0] STATION_ADDR = 48'h6655_4433_2211
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic              bus_wide_i,
  input  logic [OFS_W-1:0]  bus_ofs_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ev_txtimeout_i,
  input  logic              ev_collision_i,
  input  logic              ev_missed_i,
  input  logic              ev_memerr_i,
  input  logic              ev_rxdone_i,
  input  logic              ev_txdone_i,
  input  logic              init_done_i,
  output logic              init_req_o,
  output logic              tx_poll_o,
  output logic              irq_o,
  output logic [31:0]       ib_addr_o,
  output logic              idon_mask_o,
  output logic              auto_pad_o,
  output logic [DATA_W-1:0] bus_style_o
);
  port_e             port;
  logic [IDX_W-1:0]  idx_q;
  logic              idx_wr, data_wr, bus_wr, cmd_wr, soft_rst;
  logic [DATA_W-1:0] csr0, cfg_rdata, bus_rdata, prom_lo, prom_hi;

  nicw_port_decode u_dec (
    .wide_i (bus_wide_i),
    .ofs_i  (bus_ofs_i),
    .port_o (port)
  );

  assign idx_wr   = bus_sel_i &&  bus_wr_i && (port == PORT_INDEX);
  assign data_wr  = bus_sel_i &&  bus_wr_i && (port == PORT_DATA);
  assign bus_wr   = bus_sel_i &&  bus_wr_i && (port == PORT_BUS);
  assign soft_rst = bus_sel_i && !bus_wr_i && (port == PORT_RESET);
  assign cmd_wr   = data_wr && (idx_q == IDX_W'(IDX_CMD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idx_q <= '0;
    else if (idx_wr || soft_rst)  idx_q <= soft_rst ? '0 : bus_wdata_i[IDX_W-1:0];
  end

  nicw_cmd_status u_cmd (
    .clk            (clk),
    .rst_n          (rst_n),
    .soft_rst_i     (soft_rst),
    .wr_i           (cmd_wr),
    .wdata_i        (bus_wdata_i),
    .ev_txtimeout_i (ev_txtimeout_i),
    .ev_collision_i (ev_collision_i),
    .ev_missed_i    (ev_missed_i),
    .ev_memerr_i    (ev_memerr_i),
    .ev_rxdone_i    (ev_rxdone_i),
    .ev_txdone_i    (ev_txdone_i),
    .init_done_i    (init_done_i),
    .idon_mask_i    (idon_mask_o),
    .csr0_o         (csr0),
    .irq_o          (irq_o),
    .init_req_o     (init_req_o),
    .tx_poll_o      (tx_poll_o)
  );

  nicw_cfg_regs #(.IDX_W(IDX_W), .CHIP_ID(CHIP_ID)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst_i  (soft_rst),
    .csr_wr_i    (data_wr),
    .bus_wr_i    (bus_wr),
    .idx_i       (idx_q),
    .wdata_i     (bus_wdata_i),
    .csr_rdata_o (cfg_rdata),
    .bus_rdata_o (bus_rdata),
    .ib_addr_o   (ib_addr_o),
    .idon_mask_o (idon_mask_o),
    .auto_pad_o  (auto_pad_o),
    .bus_style_o (bus_style_o)
  );

  function automatic logic [15:0] ea_half(input logic [2:0] h);
    case (h)
      3'd0:    ea_half = STATION_ADDR[15:0];
      3'd1:    ea_half = STATION_ADDR[31:16];
      3'd2:    ea_half = STATION_ADDR[47:32];
      default: ea_half = '0;
    endcase
  endfunction

  always_comb begin
    prom_lo = '0;
    prom_hi = '0;
    if (!bus_ofs_i[0]) begin
      prom_lo = ea_half(bus_ofs_i[3:1]);
      if (bus_wide_i && !bus_ofs_i[1]) prom_hi = ea_half(bus_ofs_i[3:1] + 3'd1);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (port)
      PORT_PROM:  bus_rdata_o = {prom_hi, prom_lo};
      PORT_INDEX: bus_rdata_o = 32'(idx_q);
      PORT_DATA:  bus_rdata_o = {16'h0, (idx_q == IDX_W'(IDX_CMD)) ? csr0 : cfg_rdata};
      PORT_BUS:   bus_rdata_o = {16'h0, bus_rdata};
      default:    bus_rdata_o = '0;
    endcase
  end

  // R1: a software reset restores the stop-only command word
  p_softrst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (csr0 == 16'h0004 && idx_q == '0));
  // R3: the index only moves on an index write or reset
  p_idx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !soft_rst) |=> $stable(idx_q));
endmodule

// File: tb/sim_ctl_reg_window.sv
`timescale 1ns/1ps
module sim_ctl_reg_window;
  logic clk = 1'b0;
  logic rst_n;
  logic sel, wr, wide;
  logic [4:0]  ofs;
  logic [15:0] wdata;
  logic [31:0] rdata;
  logic ev_to, ev_col, ev_miss, ev_mem, ev_rx, ev_tx, idone;
  logic init_req, tx_poll, irq, idon_mask, auto_pad;
  logic [31:0] ib_addr;
  logic [15:0] bstyle;
  int nchecks = 0;
  int nerrs = 0;
  logic [31:0] got;

  always #2.5 clk = ~clk;

  ctl_reg_window u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_wide_i(wide),
    .bus_ofs_i(ofs), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ev_txtimeout_i(ev_to), .ev_collision_i(ev_col), .ev_missed_i(ev_miss),
    .ev_memerr_i(ev_mem), .ev_rxdone_i(ev_rx), .ev_txdone_i(ev_tx),
    .init_done_i(idone), .init_req_o(init_req), .tx_poll_o(tx_poll), .irq_o(irq),
    .ib_addr_o(ib_addr), .idon_mask_o(idon_mask), .auto_pad_o(auto_pad),
    .bus_style_o(bstyle)
  );

  // entry: {write, wide, offset[4:0], wdata[15:0], expected read[31:0]}
  localparam int NVEC = 30;
  localparam logic [54:0] VEC [NVEC] = '{
    {1'b1,1'b1,5'h14,16'd1,    32'h0},          // R3 index 1
    {1'b1,1'b1,5'h10,16'h1234, 32'h0},
    {1'b0,1'b1,5'h10,16'h0,    32'h0000_1234},  // R3
    {1'b0,1'b1,5'h14,16'h0,    32'h0000_0001},  // R3 index readback
    {1'b1,1'b0,5'h12,16'd2,    32'h0},          // R2 narrow index port
    {1'b1,1'b0,5'h10,16'hABCD, 32'h0},
    {1'b0,1'b0,5'h10,16'h0,    32'h0000_ABCD},  // R2
    {1'b0,1'b0,5'h12,16'h0,    32'h0000_0002},  // R2
    {1'b1,1'b1,5'h14,16'd1,    32'h0},
    {1'b0,1'b0,5'h10,16'h0,    32'h0000_1234},  // R2 cross-mode
    {1'b1,1'b0,5'h12,16'd88,   32'h0},
    {1'b0,1'b0,5'h10,16'h0,    32'h0000_0003},  // R10
    {1'b1,1'b0,5'h10,16'hFFFF, 32'h0},
    {1'b0,1'b0,5'h10,16'h0,    32'h0000_0003},  // R10 write ignored
    {1'b1,1'b1,5'h14,16'd89,   32'h0},
    {1'b0,1'b1,5'h10,16'h0,    32'h0000_0242},  // R10
    {1'b1,1'b1,5'h14,16'd50,   32'h0},
    {1'b1,1'b1,5'h10,16'hBEEF, 32'h0},
    {1'b0,1'b1,5'h10,16'h0,    32'h0},          // R3 unimplemented
    {1'b1,1'b1,5'h14,16'd20,   32'h0},
    {1'b1,1'b1,5'h1C,16'h0002, 32'h0},
    {1'b0,1'b1,5'h1C,16'h0,    32'h0000_0002},  // R12
    {1'b0,1'b0,5'h16,16'h0,    32'h0000_0002},  // R12 narrow bus port
    {1'b0,1'b1,5'h10,16'h0,    32'h0},          // R3 index 20 in register space
    {1'b0,1'b1,5'h00,16'h0,    32'h4433_2211},  // R13
    {1'b0,1'b0,5'h00,16'h0,    32'h0000_2211},  // R13
    {1'b0,1'b0,5'h02,16'h0,    32'h0000_4433},  // R13
    {1'b0,1'b0,5'h04,16'h0,    32'h0000_6655},  // R13
    {1'b0,1'b1,5'h04,16'h0,    32'h0000_6655},  // R13
    {1'b0,1'b0,5'h18,16'h0,    32'h0}           // R2 hole in narrow map
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nerrs++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", what, act, exp);
    end
  endtask

  task automatic do_write(input logic w, input logic [4:0] o, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; wide = w; ofs = o; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic do_read(input logic w, input logic [4:0] o, output logic [31:0] v);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; wide = w; ofs = o;
    #1 v = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic cmd_read(output logic [31:0] v);
    do_read(1'b1, 5'h10, v);
  endtask

  task automatic cmd_write(input logic [15:0] d);
    do_write(1'b1, 5'h10, d);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_to = 1'b1;   1: ev_col = 1'b1;  2: ev_miss = 1'b1;
      3: ev_mem = 1'b1;  4: ev_rx = 1'b1;   5: ev_tx = 1'b1;
      default: idone = 1'b1;
    endcase
    @(negedge clk);
    {ev_to, ev_col, ev_miss, ev_mem, ev_rx, ev_tx, idone} = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerrs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; wide = 1'b1; ofs = '0; wdata = '0;
    {ev_to, ev_col, ev_miss, ev_mem, ev_rx, ev_tx, idone} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    cmd_read(got);
    check("R1 reset command word", got, 32'h0000_0004);
    check("R1 reset outputs", {29'h0, irq, init_req, tx_poll}, 32'h0);
    check("R1 reset init-block address", ib_addr, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][54]) do_write(VEC[i][53], VEC[i][52:48], VEC[i][47:32]);
      else begin
        do_read(VEC[i][53], VEC[i][52:48], got);
        check($sformatf("R2/R3/R10/R12/R13 table step %0d", i), got, VEC[i][31:0]);
      end
    end

    check("R11 init-block address", ib_addr, 32'hABCD_1234);
    check("R12 bus style output", {16'h0, bstyle}, 32'h2);
    do_write(1'b1, 5'h14, 16'd4);
    do_write(1'b1, 5'h10, 16'h0800);
    check("R11 auto pad", {31'h0, auto_pad}, 32'h1);

    do_write(1'b1, 5'h14, 16'd0);
    // R8 init request
    cmd_write(16'h0001);
    check("R8 init pulse high", {31'h0, init_req}, 32'h1);
    @(negedge clk);
    check("R8 init pulse one cycle", {31'h0, init_req}, 32'h0);
    cmd_read(got);
    check("R8 init bit reads zero", got, 32'h0000_0004);
    pulse(6);
    cmd_read(got);
    check("R8 R5 init-done flag and summary", got, 32'h0000_0184);
    check("R6 no irq while disabled", {31'h0, irq}, 32'h0);
    cmd_write(16'h0040);
    cmd_read(got);
    check("R6 enable readback", got, 32'h0000_01C4);
    check("R6 irq raised", {31'h0, irq}, 32'h1);
    cmd_write(16'h0140);
    cmd_read(got);
    check("R4 clear init-done", got, 32'h0000_0044);
    check("R6 irq dropped", {31'h0, irq}, 32'h0);

    // R5 masked init-done
    do_write(1'b1, 5'h14, 16'd3);
    do_write(1'b1, 5'h10, 16'h0100);
    check("R11 idon mask output", {31'h0, idon_mask}, 32'h1);
    do_write(1'b1, 5'h14, 16'd0);
    pulse(6);
    cmd_read(got);
    check("R5 masked init-done", got, 32'h0000_0144);
    check("R5 masked no irq", {31'h0, irq}, 32'h0);
    cmd_write(16'h0140);
    do_write(1'b1, 5'h14, 16'd3);
    do_write(1'b1, 5'h10, 16'h0000);
    do_write(1'b1, 5'h14, 16'd0);

    // R4 R5 error flags
    pulse(3);
    cmd_read(got);
    check("R5 memory error summary", got, 32'h0000_88C4);
    check("R6 irq on error", {31'h0, irq}, 32'h1);
    cmd_write(16'h0040);
    cmd_read(got);
    check("R4 writing zero keeps flag", got, 32'h0000_88C4);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; wide = 1'b1; ofs = 5'h10; wdata = 16'h2040; ev_col = 1'b1;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; ev_col = 1'b0;
    cmd_read(got);
    check("R4 event beats clear", got, 32'h0000_A8C4);
    cmd_write(16'h2840);
    cmd_read(got);
    check("R4 clear two flags", got, 32'h0000_0044);
    pulse(0);
    cmd_read(got);
    check("R5 timeout summary", got, 32'h0000_C0C4);
    cmd_write(16'h4040);
    pulse(2);
    cmd_read(got);
    check("R5 missed summary", got, 32'h0000_90C4);
    cmd_write(16'h1040);
    pulse(4);
    pulse(5);
    cmd_read(got);
    check("R4 R5 rx and tx done", got, 32'h0000_06C4);
    cmd_write(16'h0640);
    cmd_read(got);
    check("R4 clear rx and tx", got, 32'h0000_0044);

    // R9 transmit poll
    cmd_write(16'h0048);
    check("R9 poll pulse high", {31'h0, tx_poll}, 32'h1);
    @(negedge clk);
    check("R9 poll one cycle", {31'h0, tx_poll}, 32'h0);
    cmd_read(got);
    check("R9 poll bit reads zero", got, 32'h0000_0044);

    // R7 start and stop
    cmd_write(16'h0042);
    cmd_read(got);
    check("R7 start", got, 32'h0000_0072);
    cmd_write(16'h0046);
    cmd_read(got);
    check("R7 stop wins over start", got, 32'h0000_0044);
    cmd_write(16'h0042);
    cmd_write(16'h0044);
    cmd_read(got);
    check("R7 stop after start", got, 32'h0000_0044);
    cmd_write(16'h0045);
    check("R8 init suppressed by stop", {31'h0, init_req}, 32'h0);

    // R1 software reset, wide then narrow
    do_write(1'b1, 5'h14, 16'd1);
    do_read(1'b1, 5'h18, got);
    check("R1 reset port reads zero", got, 32'h0);
    cmd_read(got);
    check("R1 soft reset command word", got, 32'h0000_0004);
    check("R1 soft reset config", {ib_addr[15:0], bstyle}, 32'h0);
    check("R1 soft reset mode bits", {30'h0, auto_pad, idon_mask}, 32'h0);
    do_write(1'b1, 5'h14, 16'd1);
    do_write(1'b1, 5'h10, 16'h0055);
    do_read(1'b0, 5'h14, got);
    do_read(1'b0, 5'h12, got);
    check("R1 R2 narrow reset clears index", got, 32'h0);
    do_write(1'b1, 5'h14, 16'd1);
    do_read(1'b1, 5'h10, got);
    check("R1 narrow reset clears register 1", got, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule